// File: doc/BRIEF.md
# Debug Entry and Memory Steering Controller

This controller switches a processor between running user code from target memory and running a debug monitor from local shadow ROM/RAM. Entry can be requested by several sources at once: a host debug command, a serial-port receive interrupt and a trace trigger. Requests are merged into one pending set. At the next bus-idle cycle the controller swaps the processor's whole memory space over to shadow memory. It then drives a non-maskable interrupt pulse of programmable width, so the vector fetch that follows is served from shadow ROM.

While the monitor owns the processor, the target's own NMI line is held off the processor. When the monitor strobes its exit, the controller waits until the return-from-interrupt bus cycle has completed, which is marked by the next bus-idle cycle. It then hands the bus back to the target buffers and lets target NMIs through again. A registered cause vector records which sources triggered the most recent entry. The target NMI can pass through a parameterised synchroniser chain of `SYNC_STAGES` flops (default 2).

Top module: `dbg_entry_ctrl`

## Requirements
- R1: After reset the target buffers are enabled, shadow memory is disabled, the processor NMI is low and the cause vector is zero.
- R2: While target steering is active, the processor NMI follows the target NMI delayed by exactly `SYNC_STAGES` clock cycles.
- R3: Request bits (bit 0 host command, bit 1 serial receive, bit 2 trace trigger) seen while target steering is active are held pending. On the first cycle in which `bus_idle` is high and at least one bit is pending or present, steering switches to shadow on the following cycle.
- R4: `tgt_buf_en` and `shadow_en` are always complements of each other.
- R5: The processor NMI pulse starts in the same cycle that `shadow_en` rises and lasts exactly `NMI_CYCLES` cycles.
- R6: While shadow steering is active and the entry pulse has ended, the processor NMI stays low whatever the target NMI does.
- R7: On entry, `entry_cause` takes the OR of all request bits pending or present in the entry cycle, and it holds that value until the next entry.
- R8: Requests that arrive while shadow steering is active are discarded. They cause no new entry after control returns to the target.
- R9: After a `mon_exit` strobe in monitor mode, target steering is restored on the cycle after the first `bus_idle` high cycle that follows the strobe cycle.
- R10: A `mon_exit` strobe while target steering is active, or during the entry pulse, has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| entry_req | input | N_SRC | Debug entry requests: bit 0 host, bit 1 serial receive, bit 2 trace trigger |
| tgt_nmi | input | 1 | NMI from the target system |
| bus_idle | input | 1 | High between processor bus cycles |
| mon_exit | input | 1 | One-cycle exit strobe from the monitor |
| cpu_nmi | output | 1 | NMI driven to the processor |
| tgt_buf_en | output | 1 | Enables the target address and data buffers |
| shadow_en | output | 1 | Connects shadow ROM/RAM to the processor |
| entry_cause | output | N_SRC | Request sources behind the most recent entry |

## Verification
Single-source requests issued while the bus is idle show whether each source reaches the entry path and is recorded in its own cause bit. Requests that arrive while the bus is busy, or that overlap with one another, show whether pending bits accumulate and are merged into one entry. Toggling the target NMI in user mode and again in monitor mode separates correct pass-through timing from correct masking. Exit strobes given during a busy bus, during the entry pulse and during user mode separate the correct return point from early or spurious returns. A long pseudo-random phase then mixes all inputs against the reference model.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;
   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_ENTER = 2'd1,
      ST_MON   = 2'd2,
      ST_EXIT  = 2'd3
   } dbg_state_e;
endpackage

// File: rtl/dbg_req_collect.sv
module dbg_req_collect #(
   parameter int N_SRC = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             collect,
   input  logic             take,
   input  logic [N_SRC-1:0] req_i,
   output logic [N_SRC-1:0] merged_o,
   output logic             any_o
);
   logic [N_SRC-1:0] pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pend_q <= '0;
      else if (take || !collect) pend_q <= '0;
      else                       pend_q <= pend_q | req_i;
   end

   assign merged_o = collect ? (pend_q | req_i) : '0;
   assign any_o    = |merged_o;
endmodule

// File: rtl/dbg_nmi_sync.sv
module dbg_nmi_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 0 || STAGES > 4) begin : g_bad
      $error("dbg_nmi_sync: STAGES must be 0..4");
   end

   if (STAGES == 0) begin : g_direct
      assign q_o = d_i;
   end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q <= '0;
         else        sh_q <= {sh_q[STAGES-2+1-1:0], d_i} >> 0;
      end
      assign q_o = sh_q[STAGES-1];
   end
endmodule

// File: rtl/dbg_entry_fsm.sv
module dbg_entry_fsm
   import dbg_entry_pkg::*;
#(
   parameter int NMI_CYCLES = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_any,
   input  logic       bus_idle,
   input  logic       mon_exit,
   output dbg_state_e state_o,
   output logic       take_o
);
   localparam int CNT_W = (NMI_CYCLES < 2) ? 1 : $clog2(NMI_CYCLES);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(NMI_CYCLES - 1);

   dbg_state_e       st_q, st_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   assign take_o = (st_q == ST_RUN) && req_any && bus_idle;

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      unique case (st_q)
         ST_RUN: if (take_o) begin
            st_d  = ST_ENTER;
            cnt_d = CNT_LOAD;
         end
         ST_ENTER: begin
            if (cnt_q == '0) st_d = ST_MON;
            else             cnt_d = cnt_q - 1'b1;
         end
         ST_MON:  if (mon_exit) st_d = ST_EXIT;
         ST_EXIT: if (bus_idle) st_d = ST_RUN;
         default: st_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_RUN;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

   assign state_o = st_q;
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
   import dbg_entry_pkg::*;
#(
   parameter int N_SRC       = 3,
   parameter int NMI_CYCLES  = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] entry_req,
   input  logic             tgt_nmi,
   input  logic             bus_idle,
   input  logic             mon_exit,
   output logic             cpu_nmi,
   output logic             tgt_buf_en,
   output logic             shadow_en,
   output logic [N_SRC-1:0] entry_cause
);
   if (N_SRC < 1)      begin : g_bad_src $error("dbg_entry_ctrl: N_SRC must be >= 1"); end
   if (NMI_CYCLES < 1) begin : g_bad_nmi $error("dbg_entry_ctrl: NMI_CYCLES must be >= 1"); end

   dbg_state_e       state;
   logic             take, req_any, nmi_s, in_run;
   logic [N_SRC-1:0] merged;
   logic [N_SRC-1:0] cause_q;

   assign in_run = (state == ST_RUN);

   dbg_req_collect #(.N_SRC(N_SRC)) u_collect (
      .clk(clk), .rst_n(rst_n), .collect(in_run), .take(take),
      .req_i(entry_req), .merged_o(merged), .any_o(req_any)
   );

   dbg_nmi_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(tgt_nmi), .q_o(nmi_s)
   );

   dbg_entry_fsm #(.NMI_CYCLES(NMI_CYCLES)) u_fsm (
      .clk(clk), .rst_n(rst_n), .req_any(req_any), .bus_idle(bus_idle),
      .mon_exit(mon_exit), .state_o(state), .take_o(take)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cause_q <= '0;
      else if (take) cause_q <= merged;
   end

   assign tgt_buf_en  = in_run;
   assign shadow_en   = !in_run;
   assign cpu_nmi     = (state == ST_ENTER) || (in_run && nmi_s);
   assign entry_cause = cause_q;
endmodule

// File: rtl/dbg_entry_ctrl_chk.sv
module dbg_entry_ctrl_chk #(
   parameter int N_SRC      = 3,
   parameter int NMI_CYCLES = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_idle,
   input logic             cpu_nmi,
   input logic             tgt_buf_en,
   input logic             shadow_en,
   input logic [N_SRC-1:0] entry_cause
);
   localparam int W = $clog2(NMI_CYCLES + 2) + 1;
   logic [W-1:0] width_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         width_q <= '0;
      else if (!shadow_en) width_q <= '0;
      else if (cpu_nmi)   width_q <= width_q + 1'b1;
   end

   AST_STEER_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_buf_en != shadow_en); // R4
   AST_ENTRY_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(shadow_en) |-> $past(bus_idle)); // R3
   AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(shadow_en) |-> cpu_nmi); // R5
   AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      (shadow_en && $fell(cpu_nmi)) |-> width_q == W'(NMI_CYCLES)); // R5
   AST_NMI_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (shadow_en && $past(shadow_en) && !$past(cpu_nmi)) |-> !cpu_nmi); // R6
   AST_CAUSE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(shadow_en) |-> entry_cause != '0); // R7
   AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(shadow_en) |-> $stable(entry_cause)); // R7
   AST_EXIT_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(shadow_en) |-> $past(bus_idle)); // R9
endmodule

bind dbg_entry_ctrl dbg_entry_ctrl_chk #(.N_SRC(N_SRC), .NMI_CYCLES(NMI_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_idle(bus_idle), .cpu_nmi(cpu_nmi),
   .tgt_buf_en(tgt_buf_en), .shadow_en(shadow_en), .entry_cause(entry_cause)
);

// File: tb/dbg_entry_ctrl_bench.sv
module dbg_entry_ctrl_bench;
   localparam int NS = 3;
   localparam int NC = 4;
   localparam int SS = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] entry_req = '0;
   logic          tgt_nmi = 1'b0;
   logic          bus_idle = 1'b1;
   logic          mon_exit = 1'b0;
   logic          cpu_nmi, tgt_buf_en, shadow_en;
   logic [NS-1:0] entry_cause;

   int compared = 0;
   int mismatched = 0;
   bit done = 0;

   always #4 clk = ~clk;

   dbg_entry_ctrl #(.N_SRC(NS), .NMI_CYCLES(NC), .SYNC_STAGES(SS)) u_dbg_entry_ctrl (
      .clk(clk), .rst_n(rst_n), .entry_req(entry_req), .tgt_nmi(tgt_nmi),
      .bus_idle(bus_idle), .mon_exit(mon_exit), .cpu_nmi(cpu_nmi),
      .tgt_buf_en(tgt_buf_en), .shadow_en(shadow_en), .entry_cause(entry_cause)
   );

   // behavioural reference: 0 user, 1 pulse, 2 monitor, 3 waiting exit
   int mode = 0;
   int pend = 0;
   int cnt = 0;
   int cause = 0;
   bit nq[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         mode = 0; pend = 0; cnt = 0; cause = 0;
         nq.delete();
         for (int i = 0; i < SS; i++) nq.push_back(1'b0);
      end else begin
         nq.push_back(tgt_nmi);
         void'(nq.pop_front());
         case (mode)
            0: begin
               pend = pend | int'(entry_req);
               if (pend != 0 && bus_idle) begin
                  mode = 1; cause = pend; pend = 0; cnt = NC;
               end
            end
            1: begin cnt--; if (cnt == 0) mode = 2; end
            2: if (mon_exit) mode = 3;
            default: if (bus_idle) mode = 0;
         endcase
      end
   end

   task automatic chk(string tag, int act, int exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      bit exp_nmi;
      exp_nmi = (mode == 1) || (mode == 0 && (SS == 0 ? tgt_nmi : nq[0]));
      chk(mode == 0 ? "R2 nmi pass" : (mode == 1 ? "R5 nmi pulse" : "R6 nmi mask"),
          int'(cpu_nmi), int'(exp_nmi));
      chk("R3 R9 tgt_buf_en", int'(tgt_buf_en), int'(mode == 0));
      chk("R4 shadow_en complement", int'(shadow_en), int'(!tgt_buf_en));
      chk("R7 entry_cause", int'(entry_cause), cause);
   endtask

   task automatic tick(input logic [NS-1:0] r, input logic n, input logic idl, input logic ex);
      @(negedge clk);
      compare_all();
      entry_req = r; tgt_nmi = n; bus_idle = idl; mon_exit = ex;
   endtask

   task automatic idle_for(int k);
      for (int i = 0; i < k; i++) tick('0, 1'b0, 1'b1, 1'b0);
   endtask

   task automatic leave_monitor();
      tick('0, 1'b0, 1'b1, 1'b1);
      idle_for(3);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 reset tgt_buf_en", int'(tgt_buf_en), 1);
      chk("R1 reset shadow_en", int'(shadow_en), 0);
      chk("R1 reset cpu_nmi", int'(cpu_nmi), 0);
      chk("R1 reset entry_cause", int'(entry_cause), 0);
      idle_for(2);
      // R2 target NMI passes with delay
      tick('0, 1'b1, 1'b1, 1'b0);
      tick('0, 1'b0, 1'b1, 1'b0);
      tick('0, 1'b1, 1'b1, 1'b0);
      tick('0, 1'b1, 1'b1, 1'b0);
      idle_for(4);
      // R10 exit strobe in user mode ignored
      tick('0, 1'b0, 1'b1, 1'b1);
      idle_for(3);
      chk("R10 stays on target", int'(tgt_buf_en), 1);
      // each single source, bus idle
      for (int s = 0; s < NS; s++) begin
         tick(NS'(1 << s), 1'b0, 1'b1, 1'b0);
         tick('0, 1'b0, 1'b1, 1'b1);   // R10 strobe during pulse ignored
         idle_for(NC + 2);
         leave_monitor();
      end
      // R3 requests while bus busy accumulate
      tick(3'b001, 1'b0, 1'b0, 1'b0);
      tick(3'b100, 1'b0, 1'b0, 1'b0);
      tick('0, 1'b0, 1'b0, 1'b0);
      tick('0, 1'b0, 1'b1, 1'b0);
      idle_for(NC + 2);
      chk("R7 merged cause", int'(entry_cause), 5);
      // R6 target NMI in monitor, R8 requests ignored
      tick(3'b111, 1'b1, 1'b1, 1'b0);
      tick(3'b010, 1'b1, 1'b0, 1'b0);
      tick('0, 1'b1, 1'b1, 1'b0);
      // R9 exit with busy bus
      tick('0, 1'b0, 1'b0, 1'b1);
      tick('0, 1'b0, 1'b0, 1'b0);
      tick('0, 1'b0, 1'b0, 1'b0);
      tick('0, 1'b0, 1'b1, 1'b0);
      idle_for(8);
      chk("R8 no re-entry after ignored requests", int'(tgt_buf_en), 1);
      // random mix
      for (int i = 0; i < 6000; i++) begin
         logic [NS-1:0] r;
         r = '0;
         for (int b = 0; b < NS; b++) r[b] = ($urandom % 20) == 0;
         tick(r, ($urandom % 4) == 0, ($urandom % 10) < 6, ($urandom % 8) == 0);
      end
      idle_for(4);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule